// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits between the decode and execute stages of a five-stage in-order pipeline. It holds the execute-stage copy of the decoded control bits and the target register of the instruction now in execute. It also watches the two source-register fields of the instruction now in decode. If the instruction in execute is a memory load and its target register is one of those sources, the loaded value cannot reach the dependent instruction in time, even with forwarding. The block then holds the pipeline for one cycle.

During that cycle, two things happen together. The fetch address register and the fetch/decode latch are told not to load, so fetch and decode work on the same instructions again. The control word written into the execute-stage register is replaced by all zeros, so the slot that moves into execute does nothing in execute, memory or write-back. Older instructions keep moving. On the next cycle the load has left execute, the bubble sits there instead, and the stall ends by itself.

Top module: `ldhz_stall_unit`

## Requirements
- R1: While reset is high at a clock edge, the execute-stage control word and target register are cleared to zero. After reset, both enables read 1 and the bubble output reads 0.
- R2: The control word bit layout is: [7] register write, [6] memory read, [5] memory write, [4] memory-to-register select, [3] ALU immediate select, [2] destination select, [1:0] ALU operation. When the stored bit [6] is 1 and the stored target register equals the decode-stage first source, in the same cycle the fetch enable is 0, the decode-latch enable is 0 and the bubble output is 1.
- R3: The same stall outputs appear when the stored bit [6] is 1 and the stored target register equals the decode-stage second source.
- R4: When the stored bit [6] is 0, there is no stall, whatever the register fields hold.
- R5: When the stored bit [6] is 1 and the stored target register matches neither source, there is no stall.
- R6: At the clock edge that ends a stall cycle, the stored control word becomes all zeros, whatever control word is presented at the input.
- R7: At any edge outside reset and without a stall, the stored control word takes the presented word. The stored target register takes the presented second-source field at every edge outside reset.
- R8: A stall never lasts longer than one cycle. In the cycle after a stall there is no stall, even if the same decode fields are still presented.
- R9: The two enables are always equal, and both are the inverse of the bubble output.
- R10: Register number 0 gets no special treatment. A load whose target is register 0 still stalls a decode-stage reader of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dec_ctrl_i | input | 8 | Control word decoded for the instruction in decode |
| dec_rs_i | input | AW | First source register field of the decode-stage instruction |
| dec_rt_i | input | AW | Second source field of the decode-stage instruction; also its load target |
| pc_we_o | output | 1 | Fetch address register load enable, active high |
| ifid_we_o | output | 1 | Fetch/decode latch load enable, active high |
| bubble_o | output | 1 | High while a stall zeroes the control word entering execute |
| ex_ctrl_o | output | 8 | Control word held for the execute stage |
| ex_rt_o | output | AW | Target register held for the execute stage |

## Verification
The detection of a hazard and the insertion of its bubble fall in the same cycle: the comparison that lowers the enables also selects zeros in place of the presented control word at the next edge. The bench provokes this by placing a load in execute and then presenting a decode-stage instruction that has a non-zero control word and a matching source field. It judges the cycle in two halves. First it checks the three stall outputs before the edge, then it checks after the edge that the stored word is zero and not the presented word. It then presents the same fields again and confirms that the stall has cleared.

// File: rtl/ldhz_pkg.sv
`timescale 1ns/1ps
package ldhz_pkg;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       mem_to_reg;
        logic       alu_imm;
        logic       dst_sel;
        logic [1:0] alu_op;
    } ex_ctrl_t;

    localparam ex_ctrl_t CTRL_NOP = '0;

    function automatic logic field_hit(input logic [31:0] a, input logic [31:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/ldhz_detect.sv
`timescale 1ns/1ps
module ldhz_detect #(
    parameter int AW = 5
) (
    input  logic          load_in_ex,
    input  logic [AW-1:0] load_dst,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    output logic          hazard
);
    import ldhz_pkg::*;

    logic [1:0] src_hit;
    logic [AW-1:0] srcs [2];

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    for (genvar g = 0; g < 2; g++) begin : g_cmp
        assign src_hit[g] = field_hit(32'(srcs[g]), 32'(load_dst));
    end

    assign hazard = load_in_ex & (|src_hit);
endmodule

// File: rtl/ldhz_idex_reg.sv
`timescale 1ns/1ps
module ldhz_idex_reg #(
    parameter int AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               zero_ctrl,
    input  ldhz_pkg::ex_ctrl_t d_ctrl,
    input  logic [AW-1:0]      d_rt,
    output ldhz_pkg::ex_ctrl_t q_ctrl,
    output logic [AW-1:0]      q_rt
);
    import ldhz_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_ctrl <= CTRL_NOP;
            q_rt   <= '0;
        end else begin
            q_ctrl <= zero_ctrl ? CTRL_NOP : d_ctrl;
            q_rt   <= d_rt;
        end
    end
endmodule

// File: rtl/ldhz_stall_unit.sv
`timescale 1ns/1ps
module ldhz_stall_unit #(
    parameter int AW = 5
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [ldhz_pkg::CTRL_W-1:0] dec_ctrl_i,
    input  logic [AW-1:0]               dec_rs_i,
    input  logic [AW-1:0]               dec_rt_i,
    output logic                        pc_we_o,
    output logic                        ifid_we_o,
    output logic                        bubble_o,
    output logic [ldhz_pkg::CTRL_W-1:0] ex_ctrl_o,
    output logic [AW-1:0]               ex_rt_o
);
    import ldhz_pkg::*;

    ex_ctrl_t      ex_ctrl;
    logic [AW-1:0] ex_rt;
    logic          stall;

    ldhz_detect #(.AW(AW)) u_detect (
        .load_in_ex (ex_ctrl.mem_rd),
        .load_dst   (ex_rt),
        .src_a      (dec_rs_i),
        .src_b      (dec_rt_i),
        .hazard     (stall)
    );

    ldhz_idex_reg #(.AW(AW)) u_idex (
        .clk       (clk_i),
        .rst       (rst_i),
        .zero_ctrl (stall),
        .d_ctrl    (ex_ctrl_t'(dec_ctrl_i)),
        .d_rt      (dec_rt_i),
        .q_ctrl    (ex_ctrl),
        .q_rt      (ex_rt)
    );

    assign pc_we_o   = ~stall;
    assign ifid_we_o = ~stall;
    assign bubble_o  = stall;
    assign ex_ctrl_o = ex_ctrl;
    assign ex_rt_o   = ex_rt;
endmodule

// File: rtl/ldhz_checker.sv
`timescale 1ns/1ps
module ldhz_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] dec_ctrl,
    input logic       pc_we,
    input logic       ifid_we,
    input logic       bubble,
    input logic [7:0] ex_ctrl
);
    // R9: both enables agree and oppose the bubble output
    p_enables_r9: assert property (@(posedge clk) disable iff (rst)
        (pc_we == ifid_we) && (pc_we != bubble));

    // R4: no load in execute means no stall
    p_no_load_r4: assert property (@(posedge clk) disable iff (rst)
        !ex_ctrl[6] |-> !bubble);

    // R6: a stall leaves an all-zero word in execute
    p_bubble_zero_r6: assert property (@(posedge clk) disable iff (rst)
        bubble |=> ex_ctrl == 8'h00);

    // R8: a stall is followed by a cycle without one
    p_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        bubble |=> !bubble);

    // R7: outside a stall the presented word is captured
    p_capture_r7: assert property (@(posedge clk) disable iff (rst)
        !bubble |=> ex_ctrl == $past(dec_ctrl));
endmodule

bind ldhz_stall_unit ldhz_checker i_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .dec_ctrl (dec_ctrl_i),
    .pc_we    (pc_we_o),
    .ifid_we  (ifid_we_o),
    .bubble   (bubble_o),
    .ex_ctrl  (ex_ctrl_o)
);

// File: tb/test_ldhz_stall_unit.sv
`timescale 1ns/1ps
module test_ldhz_stall_unit;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    dctrl = '0;
    logic [AW-1:0] drs = '0;
    logic [AW-1:0] drt = '0;
    logic          pc_we, ifid_we, bubble;
    logic [7:0]    ex_ctrl;
    logic [AW-1:0] ex_rt;

    int n_run = 0;
    int n_fail = 0;

    logic [7:0]    m_ctrl = '0;
    logic [AW-1:0] m_rt = '0;

    always #4 clk = ~clk;

    ldhz_stall_unit #(.AW(AW)) i_ldhz_stall_unit (
        .clk_i(clk), .rst_i(rst), .dec_ctrl_i(dctrl), .dec_rs_i(drs), .dec_rt_i(drt),
        .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble),
        .ex_ctrl_o(ex_ctrl), .ex_rt_o(ex_rt)
    );

    function automatic logic exp_stall(input logic [7:0] c, input logic [AW-1:0] t,
                                       input logic [AW-1:0] s, input logic [AW-1:0] u);
        return c[6] && (t == s || t == u);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: check stored state, drive, check stall outputs, clock, update model
    task automatic step(input string tag, input logic [7:0] c, input logic [AW-1:0] s,
                        input logic [AW-1:0] t);
        logic e;
        @(negedge clk);
        chk({tag, " stored ctrl"}, 32'(ex_ctrl), 32'(m_ctrl));
        chk({tag, " stored rt"}, 32'(ex_rt), 32'(m_rt));
        dctrl = c; drs = s; drt = t;
        #1;
        e = exp_stall(m_ctrl, m_rt, s, t);
        chk({tag, " stall"}, {29'd0, pc_we, ifid_we, bubble}, {29'd0, ~e, ~e, e});
        @(posedge clk);
        m_ctrl = e ? 8'h00 : c;
        m_rt = t;
    endtask

    initial begin
        #(8 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        dctrl = 8'hFF; drs = 5'd3; drt = 5'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1 ctrl", 32'(ex_ctrl), 0);
        chk("R1 rt", 32'(ex_rt), 0);
        rst = 1'b0;
        dctrl = 8'h00; drs = 5'd0; drt = 5'd0;
        #1;
        chk("R1 enables", {29'd0, pc_we, ifid_we, bubble}, 32'b110);

        // R2: load to r5, reader's first source r5
        step("R2 load", 8'hD8, 5'd1, 5'd5);
        step("R2 rs hit", 8'h86, 5'd5, 5'd9);
        step("R8 repeat", 8'h86, 5'd5, 5'd9);          // R6 stored word zero checked here
        // R3: second source matches
        step("R3 load", 8'hD8, 5'd2, 5'd7);
        step("R3 rt hit", 8'hA2, 5'd4, 5'd7);
        step("R6 after", 8'hA2, 5'd4, 5'd7);
        // R4: match but no memory read
        step("R4 nonload", 8'h86, 5'd2, 5'd6);
        step("R4 match", 8'h86, 5'd6, 5'd6);
        // R5: load with no match
        step("R5 load", 8'hD8, 5'd2, 5'd11);
        step("R5 miss", 8'h86, 5'd12, 5'd13);
        // R10: register zero is not exempt
        step("R10 load", 8'hD8, 5'd1, 5'd0);
        step("R10 hit", 8'h86, 5'd0, 5'd3);
        // R7: back-to-back loads, second one independent
        step("R7 load", 8'hD8, 5'd1, 5'd8);
        step("R7 load2", 8'hD8, 5'd2, 5'd9);
        step("R7 use", 8'h86, 5'd9, 5'd1);
        step("R9 tail", 8'h00, 5'd0, 5'd1);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            c[6] = ($urandom % 2) == 0;
            step("R9 random", c, 5'($urandom % 4), 5'($urandom % 4));
        end
        @(negedge clk);
        chk("R7 final ctrl", 32'(ex_ctrl), 32'(m_ctrl));
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule